// File: doc/BRIEF.md
# Regulator Soft-Start and Over-Current Latch-Off Sequencer

This block is the digital sequencer for a multi-phase voltage regulator. It decides when the PWM phases may switch, runs the soft-start ramp, handles an over-current episode, and drives the overvoltage crowbar flag. The analog comparators sit outside the block. They deliver single-bit flags for input supply good, power good, over-current, overvoltage, overvoltage release and a low-output condition.

A single counter stands in for the external delay capacitor. It climbs by one on each `tick` during soft start. It is loaded with its full value once power good is reached. During an over-current episode it falls by one per `tick`. If it falls to 60% of full, the sequencer shuts down for good. Only removing the supply-good or enable input brings it back. A configuration input freezes that decay, which turns the shutdown off.

When an over-current episode ends before shutdown, the next step depends on power good. If power good still holds, the counter returns to full and switching goes on. If power good has been lost, a new soft start begins from zero.

Top module: `ss_latchoff_sup`

## Requirements
- R1: While `uvlo_ok` or `en` is low, every output is low on the next clock edge: `pwm_en`, `ss_active`, `latched`, `crowbar` and `ilim_sec` are 0, and `dly_level` is 0.
- R2: One edge after `uvlo_ok` and `en` are both high, `ss_active` is 1 and `dly_level` is 0. During soft start, `dly_level` rises by one on each edge that has `tick` high and stops at FULL (default 200). Outside soft start and the over-current decay, `tick` has no effect.
- R3: During soft start, `pgood` high ends soft start at the next edge and sets `dly_level` to FULL.
- R4: In normal run with `ocp` high, each `tick` lowers `dly_level` by one. On the edge where it reaches FULL*3/5 (default 120), `latched` goes to 1 and `pwm_en` goes to 0.
- R5: If `ocp` falls before shutdown while `pgood` is high, the next edge restores `dly_level` to FULL. Normal run continues, so `pwm_en` stays 1 and `ss_active` stays 0.
- R6: If `ocp` falls before shutdown while `pgood` is low, the next edge starts a new soft start: `ss_active` is 1 and `dly_level` is 0.
- R7: Once `latched` is 1, changes on `ocp`, `pgood`, `ovp` or `tick` do not clear it. Only a low `uvlo_ok` or `en` clears it.
- R8: `ovp` high during soft start or normal run sets `crowbar` to 1 and `pwm_en` to 0 at the next edge. `crowbar` stays set until an edge with `ov_rel` high and `ovp` low.
- R9: `ilim_sec` is 1 exactly when soft start is active and `low_out` is high.
- R10: With `no_latch` high, an over-current in normal run leaves `dly_level` unchanged on every `tick`, and `latched` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Input supply above its undervoltage threshold |
| en | input | 1 | Enable |
| pgood | input | 1 | Output inside the power-good window |
| ocp | input | 1 | Over-current comparator |
| ovp | input | 1 | Output above the upper power-good limit |
| ov_rel | input | 1 | Output back below the crowbar release level |
| low_out | input | 1 | Output below the low-output threshold |
| tick | input | 1 | Delay counter step strobe |
| no_latch | input | 1 | Freeze the delay counter during over-current |
| pwm_en | output | 1 | Phases may switch |
| ss_active | output | 1 | Soft start in progress |
| latched | output | 1 | Latched off after a sustained over-current |
| crowbar | output | 1 | Overvoltage crowbar active |
| ilim_sec | output | 1 | Select the secondary current limit |
| dly_level | output | 8 | Delay counter value |

## Verification
A wrong internal state shows up at the ports within one clock edge. A stray state bit either lets `pwm_en` rise while `latched` or `crowbar` is set, or leaves `ss_active` high after power good. A wrong counter value appears directly on `dly_level`. A wrong shutdown threshold moves the edge where `latched` rises by exactly one tick away from the 80th decay tick. A fault memory that is never cleared sends a clean power-good recovery into a needless soft start. That error shows as `ss_active` high one edge after `ocp` falls.

// File: rtl/ss_latchoff_sup.sv
module ss_latchoff_sup #(
  parameter int FULL      = 200,
  parameter int LATCH_PCT = 60
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       uvlo_ok,
  input  logic                       en,
  input  logic                       pgood,
  input  logic                       ocp,
  input  logic                       ovp,
  input  logic                       ov_rel,
  input  logic                       low_out,
  input  logic                       tick,
  input  logic                       no_latch,
  output logic                       pwm_en,
  output logic                       ss_active,
  output logic                       latched,
  output logic                       crowbar,
  output logic                       ilim_sec,
  output logic [$clog2(FULL+1)-1:0]  dly_level
);
  localparam int TW = $clog2(FULL + 1);
  localparam logic [TW-1:0] FULL_V = TW'(FULL);
  localparam logic [TW-1:0] THR_P1 = TW'(FULL * LATCH_PCT / 100 + 1);

  typedef enum logic [1:0] {S_OFF, S_SOFT, S_RUN, S_LATCH} st_t;
  st_t st;
  logic [TW-1:0] tmr;
  logic flt, cb;
  wire  live = uvlo_ok & en;
  wire  active = (st == S_SOFT) | (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; tmr <= '0; flt <= 1'b0;
    end else if (!live) begin
      st <= S_OFF; tmr <= '0; flt <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin st <= S_SOFT; tmr <= '0; end
        S_SOFT:
          if (pgood) begin st <= S_RUN; tmr <= FULL_V; end
          else if (tick && tmr != FULL_V) tmr <= tmr + 1'b1;
        S_RUN:
          if (ocp) begin
            flt <= 1'b1;
            if (tick && !no_latch) begin
              tmr <= tmr - 1'b1;
              if (tmr <= THR_P1) st <= S_LATCH;
            end
          end else if (flt) begin
            flt <= 1'b0;
            if (pgood) tmr <= FULL_V;
            else begin st <= S_SOFT; tmr <= '0; end
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cb <= 1'b0;
    else if (!live)             cb <= 1'b0;
    else if (ovp && active)     cb <= 1'b1;
    else if (ov_rel)            cb <= 1'b0;
  end

  assign pwm_en    = active & ~cb;
  assign ss_active = (st == S_SOFT);
  assign latched   = (st == S_LATCH);
  assign crowbar   = cb;
  assign ilim_sec  = ss_active & low_out;
  assign dly_level = tmr;
endmodule

// File: rtl/ss_latchoff_sup_chk.sv
module ss_latchoff_sup_chk #(
  parameter int FULL      = 200,
  parameter int LATCH_PCT = 60
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      uvlo_ok,
  input logic                      en,
  input logic                      pgood,
  input logic                      ocp,
  input logic                      no_latch,
  input logic                      pwm_en,
  input logic                      ss_active,
  input logic                      latched,
  input logic                      crowbar,
  input logic [$clog2(FULL+1)-1:0] dly_level
);
  localparam int TW = $clog2(FULL + 1);
  localparam logic [TW-1:0] FULL_V = TW'(FULL);
  localparam logic [TW-1:0] THR_V  = TW'(FULL * LATCH_PCT / 100);

  assert_off_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(uvlo_ok && en) |=> (dly_level == '0 && !pwm_en && !latched));

  assert_pg_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_active && pgood && uvlo_ok && en) |=> (dly_level == FULL_V && !ss_active));

  assert_latch_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> (dly_level == THR_V && !pwm_en));

  assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && uvlo_ok && en) |=> latched);

  assert_cb_pwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar |-> !pwm_en);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_active && !latched && dly_level != '0 && uvlo_ok && en && ocp && no_latch)
      |=> $stable(dly_level));
endmodule

bind ss_latchoff_sup ss_latchoff_sup_chk #(.FULL(FULL), .LATCH_PCT(LATCH_PCT)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .en(en), .pgood(pgood), .ocp(ocp),
  .no_latch(no_latch), .pwm_en(pwm_en), .ss_active(ss_active), .latched(latched),
  .crowbar(crowbar), .dly_level(dly_level)
);

// File: tb/ss_latchoff_sup_bench.sv
module ss_latchoff_sup_bench;
  logic clk = 0, rst_n = 0;
  logic uvlo_ok = 0, en = 0, pgood = 0, ocp = 0, ovp = 0, ov_rel = 0;
  logic low_out = 0, tick = 0, no_latch = 0;
  logic pwm_en, ss_active, latched, crowbar, ilim_sec;
  logic [7:0] dly_level;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ss_latchoff_sup u_ss_latchoff_sup (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .en(en), .pgood(pgood), .ocp(ocp),
    .ovp(ovp), .ov_rel(ov_rel), .low_out(low_out), .tick(tick), .no_latch(no_latch),
    .pwm_en(pwm_en), .ss_active(ss_active), .latched(latched), .crowbar(crowbar),
    .ilim_sec(ilim_sec), .dly_level(dly_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
    tick = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
    chk("R1 pwm after reset", pwm_en, 0);
    chk("R1 dly after reset", dly_level, 0);
    chk("R1 latched after reset", latched, 0);
    chk("R1 crowbar after reset", crowbar, 0);
    ticks(3);
    chk("R2 tick ignored while off", dly_level, 0);
  endtask

  task automatic t_softstart();
    uvlo_ok = 1; en = 1; step();
    chk("R2 soft start entered", ss_active, 1);
    chk("R2 ramp starts at zero", dly_level, 0);
    chk("R2 pwm on in soft start", pwm_en, 1);
    ticks(7);
    chk("R2 ramp after 7 ticks", dly_level, 7);
    step();
    chk("R2 ramp holds without tick", dly_level, 7);
    ticks(205);
    chk("R2 ramp saturates", dly_level, 200);
  endtask

  task automatic t_pgood();
    pgood = 1; step();
    chk("R3 soft start ends", ss_active, 0);
    chk("R3 timer full", dly_level, 200);
    chk("R3 pwm on", pwm_en, 1);
  endtask

  task automatic t_ocp_good();
    ocp = 1; ticks(10);
    chk("R4 decay 10 ticks", dly_level, 190);
    ocp = 0; step();
    chk("R5 timer restored", dly_level, 200);
    chk("R5 no soft start", ss_active, 0);
    chk("R5 pwm on", pwm_en, 1);
  endtask

  task automatic t_ocp_bad();
    ocp = 1; ticks(3);
    pgood = 0; step();
    chk("R6 still run during ocp", dly_level, 197);
    ocp = 0; step();
    chk("R6 new soft start", ss_active, 1);
    chk("R6 timer zero", dly_level, 0);
    pgood = 1; step();
    chk("R3 back to run", dly_level, 200);
  endtask

  task automatic t_latch();
    ocp = 1; ticks(79);
    chk("R4 not latched at 121", latched, 0);
    chk("R4 timer 121", dly_level, 121);
    ticks(1);
    chk("R4 latched at threshold", latched, 1);
    chk("R4 timer 120", dly_level, 120);
    chk("R4 pwm off", pwm_en, 0);
    ocp = 0; pgood = 0; ovp = 1; step(); pgood = 1; ovp = 0; ticks(4);
    chk("R7 latch holds", latched, 1);
    chk("R7 timer held", dly_level, 120);
    chk("R7 pwm still off", pwm_en, 0);
    pgood = 0; uvlo_ok = 0; step();
    chk("R7 cleared by uvlo", latched, 0);
    chk("R1 dly zero", dly_level, 0);
    chk("R1 pwm off", pwm_en, 0);
    uvlo_ok = 1; step();
    chk("R2 restart soft", ss_active, 1);
    pgood = 1; step();
    chk("R3 run again", dly_level, 200);
  endtask

  task automatic t_nolatch();
    no_latch = 1; ocp = 1; ticks(100);
    chk("R10 timer frozen", dly_level, 200);
    chk("R10 not latched", latched, 0);
    ocp = 0; step(); no_latch = 0; step();
    chk("R5 run after frozen ocp", pwm_en, 1);
  endtask

  task automatic t_crowbar();
    ovp = 1; step();
    chk("R8 crowbar set", crowbar, 1);
    chk("R8 pwm off", pwm_en, 0);
    ovp = 0; step();
    chk("R8 crowbar held", crowbar, 1);
    ov_rel = 1; step(); ov_rel = 0;
    chk("R8 crowbar released", crowbar, 0);
    chk("R8 pwm back", pwm_en, 1);
  endtask

  task automatic t_secondary();
    low_out = 1; step();
    chk("R9 no secondary in run", ilim_sec, 0);
    en = 0; pgood = 0; step();
    chk("R1 ilim off when disabled", ilim_sec, 0);
    en = 1; step();
    chk("R9 secondary in soft start", ilim_sec, 1);
    low_out = 0; step();
    chk("R9 secondary off above threshold", ilim_sec, 0);
  endtask

  initial begin
    t_reset();
    t_softstart();
    t_pgood();
    t_ocp_good();
    t_ocp_bad();
    t_latch();
    t_nolatch();
    t_crowbar();
    t_secondary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule